// File: doc/BRIEF.md
# Six-Channel Simultaneous-Sampling ADC Read Sequencer

This block controls a parallel-output ADC that has six sample-and-hold channels and a 16-bit data bus. It makes the converter's clock by dividing the system clock. After power-up it pulses the converter's active-low reset once, so that the converter's internal read pointer starts at the first channel. It then waits in idle for a start request.

A start drives one shared active-low hold line low for a set number of cycles, so that all six channels sample at the same instant. The sequencer then waits for the converter's short active-low end-of-conversion pulse. It synchronises that pulse and detects its falling edge, so a pulse of only half a conversion clock is still caught. It then reads the six results with six separate chip-select and read-strobe cycles, one word each, and drives a 3-bit channel address during each. Every word leaves the block as a one-cycle valid pulse with a channel tag. A done pulse follows the last word.

If the end-of-conversion edge does not arrive within a programmable number of cycles, the sequencer raises a timeout pulse and returns to idle. While an acquisition is in progress, further starts are ignored.

Top module: `adc_read_seq`

## Requirements
- R1: `adc_clk_o` is periodic with a period of CLK_DIV system cycles (default 12). It is high for CLK_HIGH consecutive cycles of each period (default 6).
- R2: Once `rst` is released, `adc_rst_n_o` stays high for RST_CYC cycles, then low for exactly RST_CYC cycles, then high. `busy_o` stays high until this step ends, and a start during this time is ignored.
- R3: A start sampled while idle drives `adc_hold_n_o` low for exactly HOLD_CYC consecutive cycles, one pulse per acquisition. `adc_hold_n_o` and `adc_rd_n_o` are never low at the same time.
- R4: A falling edge on `adc_eoc_n_i` lasting at least two system cycles is acted on only while the sequencer waits for conversion. Such an edge in idle produces no read and no output word.
- R5: Each acquisition performs exactly six reads. In each read, `adc_cs_n_o` and `adc_rd_n_o` are low together for RD_LOW_CYC cycles. `adc_rd_n_o` is never low while `adc_cs_n_o` is high. `adc_addr_o` holds the channel index of the read: 0=A0, 1=A1, 2=B0, 3=B1, 4=C0, 5=C1.
- R6: Each read emits one cycle of `out_valid_o`. `out_ch_o` carries channel indices 0 to 5 in ascending order. `out_data_o` is the bus value held at the end of the read-strobe low time.
- R7: `done_o` pulses for one cycle, exactly one cycle after the sixth valid word.
- R8: A start while `busy_o` is high is ignored: it causes no extra hold pulse and no extra words.
- R9: A nonzero `timeout_lim_i` bounds the wait for conversion. If no end-of-conversion edge arrives within that many cycles, `timeout_o` pulses once, no word is emitted, and the sequencer returns to idle. A value of 0 disables the bound.
- R10: A start sampled in the same cycle as `done_o` is accepted and begins the next acquisition at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one acquisition |
| timeout_lim_i | input | TO_W | Cycle limit for end-of-conversion wait, 0 disables |
| adc_clk_o | output | 1 | Converter clock |
| adc_rst_n_o | output | 1 | Converter reset, active low |
| adc_hold_n_o | output | 1 | Shared hold strobe, active low |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_addr_o | output | AW | Channel address during a read |
| adc_data_i | input | DW | Converter data bus |
| adc_eoc_n_i | input | 1 | End-of-conversion pulse, active low |
| out_valid_o | output | 1 | Result word valid, one cycle |
| out_ch_o | output | CH_W | Channel tag of the result |
| out_data_o | output | DW | Result word |
| done_o | output | 1 | Acquisition complete pulse |
| timeout_o | output | 1 | Conversion wait expired pulse |
| busy_o | output | 1 | Sequencer not idle |

## Verification
The completion of one acquisition and the launch of the next can coincide: `done_o` and a new start request can share one cycle. The bench provokes this by raising `start_i` in the same cycle it observes `done_o`. It then expects a fresh hold pulse and a second set of six words, tagged 0 to 5, that carry the newly latched sample values. A second coincidence is also covered: a start that lands while a conversion is pending or words are being read. The bench judges this by counting exactly one hold pulse and six words.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_ARST,
    ST_IDLE,
    ST_HOLD,
    ST_WAIT,
    ST_RDLO,
    ST_RDHI
  } seq_state_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int CLK_DIV  = 12,
  parameter int CLK_HIGH = 6
) (
  input  logic clk,
  input  logic rst,
  output logic clk_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else begin
      cnt   <= (cnt == CW'(CLK_DIV - 1)) ? '0 : cnt + CW'(1);
      clk_o <= (cnt < CW'(CLK_HIGH));
    end
  end
endmodule

// File: rtl/adc_eoc_edge.sv
module adc_eoc_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic eoc_n_i,
  output logic fall_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], eoc_n_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC-1];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH     = 6,
  parameter int DW         = 16,
  parameter int AW         = 3,
  parameter int HOLD_CYC   = 3,
  parameter int RD_LOW_CYC = 3,
  parameter int RST_CYC    = 8,
  parameter int TO_W       = 16,
  parameter int CH_W       = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            eoc_fall_i,
  input  logic [TO_W-1:0] timeout_lim_i,
  input  logic [DW-1:0]   adc_data_i,
  output logic            adc_rst_n_o,
  output logic            adc_hold_n_o,
  output logic            adc_cs_n_o,
  output logic            adc_rd_n_o,
  output logic [AW-1:0]   adc_addr_o,
  output logic            out_valid_o,
  output logic [CH_W-1:0] out_ch_o,
  output logic [DW-1:0]   out_data_o,
  output logic            done_o,
  output logic            timeout_o,
  output logic            busy_o
);
  seq_state_t      state;
  logic [TO_W-1:0] cnt;
  logic [CH_W-1:0] ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_PWRUP;
      cnt          <= '0;
      ch           <= '0;
      adc_rst_n_o  <= 1'b1;
      adc_hold_n_o <= 1'b1;
      adc_cs_n_o   <= 1'b1;
      adc_rd_n_o   <= 1'b1;
      adc_addr_o   <= '0;
      out_valid_o  <= 1'b0;
      out_ch_o     <= '0;
      out_data_o   <= '0;
      done_o       <= 1'b0;
      timeout_o    <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
      timeout_o   <= 1'b0;
      unique case (state)
        ST_PWRUP: begin
          if (cnt == TO_W'(RST_CYC - 1)) begin
            cnt         <= '0;
            adc_rst_n_o <= 1'b0;
            state       <= ST_ARST;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        ST_ARST: begin
          if (cnt == TO_W'(RST_CYC - 1)) begin
            cnt         <= '0;
            adc_rst_n_o <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        ST_IDLE: begin
          cnt <= '0;
          ch  <= '0;
          if (start_i) begin
            adc_hold_n_o <= 1'b0;
            adc_addr_o   <= '0;
            state        <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt == TO_W'(HOLD_CYC - 1)) begin
            cnt          <= '0;
            adc_hold_n_o <= 1'b1;
            state        <= ST_WAIT;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        ST_WAIT: begin
          if (eoc_fall_i) begin
            cnt        <= '0;
            adc_cs_n_o <= 1'b0;
            adc_rd_n_o <= 1'b0;
            state      <= ST_RDLO;
          end else if ((timeout_lim_i != '0) && (cnt == timeout_lim_i - TO_W'(1))) begin
            cnt       <= '0;
            timeout_o <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        ST_RDLO: begin
          if (cnt == TO_W'(RD_LOW_CYC - 1)) begin
            cnt         <= '0;
            out_valid_o <= 1'b1;
            out_ch_o    <= ch;
            out_data_o  <= adc_data_i;
            adc_cs_n_o  <= 1'b1;
            adc_rd_n_o  <= 1'b1;
            state       <= ST_RDHI;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        ST_RDHI: begin
          if (ch == CH_W'(NUM_CH - 1)) begin
            ch     <= '0;
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            ch         <= ch + CH_W'(1);
            adc_addr_o <= AW'(ch + CH_W'(1));
            adc_cs_n_o <= 1'b0;
            adc_rd_n_o <= 1'b0;
            state      <= ST_RDLO;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq #(
  parameter int NUM_CH     = 6,
  parameter int DW         = 16,
  parameter int AW         = 3,
  parameter int CLK_DIV    = 12,
  parameter int CLK_HIGH   = 6,
  parameter int HOLD_CYC   = 3,
  parameter int RD_LOW_CYC = 3,
  parameter int RST_CYC    = 8,
  parameter int SYNC       = 2,
  parameter int TO_W       = 16,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [TO_W-1:0] timeout_lim_i,
  output logic            adc_clk_o,
  output logic            adc_rst_n_o,
  output logic            adc_hold_n_o,
  output logic            adc_cs_n_o,
  output logic            adc_rd_n_o,
  output logic [AW-1:0]   adc_addr_o,
  input  logic [DW-1:0]   adc_data_i,
  input  logic            adc_eoc_n_i,
  output logic            out_valid_o,
  output logic [CH_W-1:0] out_ch_o,
  output logic [DW-1:0]   out_data_o,
  output logic            done_o,
  output logic            timeout_o,
  output logic            busy_o
);
  logic eoc_fall;

  adc_clk_div #(
    .CLK_DIV (CLK_DIV),
    .CLK_HIGH(CLK_HIGH)
  ) u_clkdiv (
    .clk  (clk),
    .rst  (rst),
    .clk_o(adc_clk_o)
  );

  adc_eoc_edge #(
    .SYNC(SYNC)
  ) u_eoc (
    .clk    (clk),
    .rst    (rst),
    .eoc_n_i(adc_eoc_n_i),
    .fall_o (eoc_fall)
  );

  adc_seq_fsm #(
    .NUM_CH    (NUM_CH),
    .DW        (DW),
    .AW        (AW),
    .HOLD_CYC  (HOLD_CYC),
    .RD_LOW_CYC(RD_LOW_CYC),
    .RST_CYC   (RST_CYC),
    .TO_W      (TO_W),
    .CH_W      (CH_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .eoc_fall_i   (eoc_fall),
    .timeout_lim_i(timeout_lim_i),
    .adc_data_i   (adc_data_i),
    .adc_rst_n_o  (adc_rst_n_o),
    .adc_hold_n_o (adc_hold_n_o),
    .adc_cs_n_o   (adc_cs_n_o),
    .adc_rd_n_o   (adc_rd_n_o),
    .adc_addr_o   (adc_addr_o),
    .out_valid_o  (out_valid_o),
    .out_ch_o     (out_ch_o),
    .out_data_o   (out_data_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk #(
  parameter int NUM_CH   = 6,
  parameter int CLK_HIGH = 6,
  parameter int HOLD_CYC = 3,
  parameter int CH_W     = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            adc_clk_o,
  input logic            adc_hold_n_o,
  input logic            adc_cs_n_o,
  input logic            adc_rd_n_o,
  input logic            out_valid_o,
  input logic [CH_W-1:0] out_ch_o,
  input logic            done_o,
  input logic            timeout_o
);
  logic [15:0] clk_hi_run;
  logic [15:0] hold_lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_hi_run  <= '0;
      hold_lo_run <= '0;
    end else begin
      clk_hi_run  <= adc_clk_o ? clk_hi_run + 16'd1 : '0;
      hold_lo_run <= !adc_hold_n_o ? hold_lo_run + 16'd1 : '0;
    end
  end

  // R1
  clk_high_len_chk: assert property (@(posedge clk) disable iff (rst)
    clk_hi_run <= 16'(CLK_HIGH));

  // R3
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    hold_lo_run <= 16'(HOLD_CYC));

  // R3
  hold_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!adc_hold_n_o && !adc_rd_n_o));

  // R5
  rd_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n_o |-> !adc_cs_n_o);

  // R6
  ch_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (out_ch_o < CH_W'(NUM_CH)));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(out_valid_o) && $past(out_ch_o) == CH_W'(NUM_CH - 1)));

  // R9
  timeout_no_word_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!out_valid_o && !done_o));
endmodule

bind adc_read_seq adc_read_seq_chk #(
  .NUM_CH  (NUM_CH),
  .CLK_HIGH(CLK_HIGH),
  .HOLD_CYC(HOLD_CYC),
  .CH_W    (CH_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .adc_clk_o   (adc_clk_o),
  .adc_hold_n_o(adc_hold_n_o),
  .adc_cs_n_o  (adc_cs_n_o),
  .adc_rd_n_o  (adc_rd_n_o),
  .out_valid_o (out_valid_o),
  .out_ch_o    (out_ch_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o)
);

// File: tb/test_adc_read_seq.sv
`timescale 1ns/1ps
module test_adc_read_seq;
  localparam int NCH = 6;
  localparam int DIV = 12;
  localparam int HI = 6;
  localparam int HOLD = 3;
  localparam int RDLO = 3;
  localparam int RSTC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] tlim = 16'd200;
  logic adc_clk, adc_rst_n, hold_n, cs_n, rd_n;
  logic [2:0] addr;
  wire  [15:0] dbus;
  logic eoc_n = 1'b1;
  logic vld, done, tmo, busy;
  logic [2:0] och;
  logic [15:0] odata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_read_seq i_adc_read_seq (
    .clk(clk), .rst(rst), .start_i(start), .timeout_lim_i(tlim),
    .adc_clk_o(adc_clk), .adc_rst_n_o(adc_rst_n), .adc_hold_n_o(hold_n),
    .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n), .adc_addr_o(addr),
    .adc_data_i(dbus), .adc_eoc_n_i(eoc_n), .out_valid_o(vld),
    .out_ch_o(och), .out_data_o(odata), .done_o(done),
    .timeout_o(tmo), .busy_o(busy)
  );

  // ---------------- behavioural converter ----------------
  logic [15:0] base = 16'h0;
  logic [15:0] samp [NCH];
  logic [15:0] dbuf = 16'h0;
  int ptr = 0;
  int addr_err = 0;
  bit eoc_en = 1'b1;
  bit eoc_kick = 1'b0;

  assign dbus = cs_n ? 16'hzzzz : dbuf;

  always @(negedge adc_rst_n) ptr = 0;

  always @(negedge hold_n)
    for (int i = 0; i < NCH; i++) samp[i] = base + 16'(i);

  always @(negedge rd_n) begin
    if (cs_n || addr != 3'(ptr)) addr_err++;
    dbuf = samp[ptr];
    ptr = (ptr == NCH - 1) ? 0 : ptr + 1;
  end

  always @(negedge hold_n or eoc_kick) begin
    if (eoc_en) begin
      #200;
      eoc_n = 1'b0;
      #20;
      eoc_n = 1'b1;
    end
  end

  // ---------------- monitor ----------------
  int cyc = 0;
  int hold_run = 0, hold_last = 0, hold_cnt = 0;
  int rd_run = 0, rd_cnt = 0, rd_bad = 0;
  int rl_run = 0, rl_last = 0;
  int hi_run = 0, hi_last = 0, per_run = 0, per_last = 0;
  bit clk_prev = 1'b0;
  int nvalid = 0, ndone = 0, ntmo = 0, last_vcyc = 0, done_gap = 0;
  logic [2:0]  got_ch [32];
  logic [15:0] got_d  [32];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!hold_n) hold_run++;
      else if (hold_run != 0) begin hold_last = hold_run; hold_run = 0; hold_cnt++; end
      if (!rd_n) rd_run++;
      else if (rd_run != 0) begin if (rd_run != RDLO) rd_bad++; rd_run = 0; rd_cnt++; end
      if (!adc_rst_n) rl_run++;
      else if (rl_run != 0) begin rl_last = rl_run; rl_run = 0; end
      if (adc_clk) hi_run++;
      else if (hi_run != 0) begin hi_last = hi_run; hi_run = 0; end
      if (adc_clk && !clk_prev) begin per_last = per_run; per_run = 1; end
      else per_run++;
      clk_prev = adc_clk;
      if (vld) begin
        if (nvalid < 32) begin got_ch[nvalid] = och; got_d[nvalid] = odata; end
        nvalid++;
        last_vcyc = cyc;
      end
      if (done) begin ndone++; done_gap = cyc - last_vcyc; end
      if (tmo) ntmo++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    hold_cnt = 0; rd_cnt = 0; rd_bad = 0; nvalid = 0; ndone = 0; ntmo = 0;
    addr_err = 0; hold_last = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 1000 && ndone < n; k++) @(negedge clk);
  endtask

  task automatic check_words(input int first, input logic [15:0] b, input string req);
    for (int i = 0; i < NCH; i++)
      chk(got_ch[first+i] == 3'(i) && got_d[first+i] == b + 16'(i), req,
          int'(got_d[first+i]), int'(b + 16'(i)));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(adc_rst_n && hold_n && cs_n && rd_n && !vld && !done && !tmo, "R2 reset state",
        {adc_rst_n, hold_n, cs_n, rd_n}, 4'hF);
    rst = 1'b0;
    start = 1'b1;           // R2: start during converter reset step is ignored
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(rl_last == RSTC, "R2 reset low length", rl_last, RSTC);
    chk(hold_cnt == 0 && hold_n, "R2 start ignored during reset step", hold_cnt, 0);
    chk(!busy, "R2 idle after reset step", busy, 0);
  endtask

  task automatic t_clock();
    repeat (40) @(negedge clk);
    chk(hi_last == HI, "R1 converter clock high time", hi_last, HI);
    chk(per_last == DIV, "R1 converter clock period", per_last, DIV);
  endtask

  task automatic t_single();
    clear_mon();
    base = 16'h1230;
    pulse_start();
    wait_done(1);
    repeat (2) @(negedge clk);
    chk(hold_cnt == 1 && hold_last == HOLD, "R3 hold pulse", hold_last, HOLD);
    chk(rd_cnt == NCH && rd_bad == 0, "R5 six reads of correct width", rd_cnt, NCH);
    chk(addr_err == 0, "R5 address matches read order", addr_err, 0);
    chk(nvalid == NCH, "R6 word count", nvalid, NCH);
    check_words(0, 16'h1230, "R6 tag/data");
    chk(ndone == 1 && done_gap == 1, "R7 done one cycle after last word", done_gap, 1);
    chk(ntmo == 0, "R9 no timeout in normal run", ntmo, 0);
  endtask

  task automatic t_busy_start();
    clear_mon();
    base = 16'h4000;
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();           // during hold/wait
    for (int k = 0; k < 200 && nvalid < 2; k++) @(negedge clk);
    pulse_start();           // during reads
    wait_done(1);
    repeat (20) @(negedge clk);
    chk(hold_cnt == 1, "R8 one hold pulse despite extra starts", hold_cnt, 1);
    chk(nvalid == NCH, "R8 six words only", nvalid, NCH);
    check_words(0, 16'h4000, "R8 data");
  endtask

  task automatic t_stray_eoc();
    clear_mon();
    eoc_kick = ~eoc_kick;    // pulse while idle
    repeat (60) @(negedge clk);
    chk(nvalid == 0 && rd_cnt == 0 && !busy, "R4 idle edge ignored", nvalid, 0);
    base = 16'h5550;
    pulse_start();
    wait_done(1);
    repeat (2) @(negedge clk);
    check_words(0, 16'h5550, "R4 order intact after stray edge");
  endtask

  task automatic t_timeout();
    clear_mon();
    eoc_en = 1'b0;
    tlim = 16'd40;
    pulse_start();
    for (int k = 0; k < 200 && ntmo == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ntmo == 1, "R9 timeout pulse", ntmo, 1);
    chk(nvalid == 0 && ndone == 0 && rd_cnt == 0, "R9 no words", nvalid, 0);
    chk(!busy, "R9 back to idle", busy, 0);
    eoc_en = 1'b1;
    tlim = 16'd200;
    clear_mon();
    base = 16'h6660;
    pulse_start();
    wait_done(1);
    repeat (2) @(negedge clk);
    check_words(0, 16'h6660, "R9 recovery");
  endtask

  task automatic t_back2back();
    clear_mon();
    base = 16'h7000;
    pulse_start();
    for (int k = 0; k < 1000 && !done; k++) @(negedge clk);
    base = 16'h8000;
    start = 1'b1;            // same cycle as done
    @(negedge clk) start = 1'b0;
    wait_done(2);
    repeat (2) @(negedge clk);
    chk(hold_cnt == 2, "R10 second hold pulse", hold_cnt, 2);
    chk(nvalid == 2 * NCH, "R10 twelve words", nvalid, 2 * NCH);
    check_words(0, 16'h7000, "R10 first set");
    check_words(NCH, 16'h8000, "R10 second set");
  endtask

  initial begin
    t_reset();
    t_clock();
    t_single();
    t_busy_start();
    t_stray_eoc();
    t_timeout();
    t_back2back();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule